// File: doc/BRIEF.md
# Asynchronous Serial Receiver

This block recovers character frames from a single serial input line whose sender runs on a clock of its own. That clock may differ from the local clock in both frequency and phase. The line first passes through a two-stage synchronizer. The receiver then waits for a high-to-low transition on the idle line. It confirms the start bit half a bit period later. After that it samples each following bit one full bit period after the previous sample, so every sample falls near the middle of its bit. Because the timing restarts on every start edge, a small rate error builds up over one frame only.

Sampled bits enter a shift register, least significant bit first. When the last stop bit has been sampled, the whole group is copied in one step into an 8-bit output register, a one-cycle valid pulse is raised, and the parity and framing results are registered next to it. The receiver and the matching transmitter share one configuration. It sets 7 or 8 group bits, parity on or off, even or odd parity, one or two stop bits, and the number of clocks per bit.

The controller is a state machine with five states:
- `RX_IDLE` waits for a falling edge.
- `RX_START` checks the start bit at mid-bit. It leaves for `RX_DATA` if the line is still low, or goes back to `RX_IDLE` if the line has returned high.
- `RX_DATA` shifts in one bit per period. It moves to `RX_STOP` after the last group bit.
- `RX_STOP` samples one or two stop bits, then moves to `RX_DONE`.
- `RX_DONE` updates the outputs for one cycle, then returns to `RX_IDLE`.

Top module: `async_rx`

## Requirements
- R1: After reset `rx_data` is 0 and `rx_valid`, `rx_par_err` and `rx_frm_err` are 0.
- R2: A low pulse on `rx_line` that has ended before half a bit period (`cfg_div/2` clocks) is ignored: no valid pulse, and the next proper frame is received correctly.
- R3: Group bits are received least significant bit first. The first data bit lands in `rx_data[0]`. With `cfg_len8`=0 the group has 7 bits and `rx_data[7]` reads 0.
- R4: Each accepted frame produces exactly one `rx_valid` pulse, one clock wide.
- R5: With `cfg_par_en`=1, the group's most significant bit (bit 7 or bit 6) is the parity bit and stays in `rx_data`. `rx_par_err` is 1 when the number of 1s in the group is odd while `cfg_par_odd`=0, or even while `cfg_par_odd`=1.
- R6: With `cfg_par_en`=0, `rx_par_err` is 0 on every valid pulse.
- R7: `rx_frm_err` is 1 when any expected stop bit is sampled as 0.
- R8: With `cfg_two_stop`=1 both stop bits are sampled. A 0 in either one sets `rx_frm_err`.
- R9: With `cfg_div`=32, frames sent at 31 or 33 clocks per bit are received without error.
- R10: `rx_data`, `rx_par_err` and `rx_frm_err` change only together with a valid pulse, and hold their values between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_line | input | 1 | Serial input; idles high |
| cfg_len8 | input | 1 | 1: 8 group bits; 0: 7 group bits |
| cfg_par_en | input | 1 | 1: group MSB is a parity bit |
| cfg_par_odd | input | 1 | 1: odd parity; 0: even parity |
| cfg_two_stop | input | 1 | 1: two stop bits; 0: one |
| cfg_div | input | DIV_W | Clocks per bit, at least 4 |
| rx_data | output | 8 | Last received group |
| rx_valid | output | 1 | One-clock pulse when `rx_data` updates |
| rx_par_err | output | 1 | Parity result of the last group |
| rx_frm_err | output | 1 | Stop-bit result of the last frame |

## Verification
The hardest cases to reach are a clock mismatch and a false start. For the mismatch, the bench drives frames whose bit period differs from `cfg_div` by about three percent, so the last stop-bit sample lands close to the end of that bit. For the false start, it drops the line for only a few clocks, so the start is abandoned in `RX_START`. After that it sends a proper frame to show that receiving has recovered. Parity and stop-bit faults are injected on purpose in a sweep over all sixteen configurations, and the first and the second stop bit are each tested separately.

// File: rtl/rx_pkg.sv
package rx_pkg;
    localparam int GROUP_MAX = 8;
    localparam int CNT_W     = $clog2(GROUP_MAX);

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_DONE
    } rx_state_e;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_out
);
    logic [STAGES-1:0] chain;

    // Reset to 1 so that an idle line shows no false start edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], line_in};
    end

    assign line_out = chain[STAGES-1];
endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         tick
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    // Fires load_val+1 cycles after a load.
    assign tick = (cnt == '0);
endmodule

// File: rtl/rx_parity_check.sv
module rx_parity_check #(
    parameter int N = 8
) (
    input  logic [N-1:0] group,
    input  logic         par_en,
    input  logic         par_odd,
    output logic         par_err
);
    assign par_err = par_en & ((^group) ^ par_odd);
endmodule

// File: rtl/async_rx.sv
module async_rx
    import rx_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_line,
    input  logic             cfg_len8,
    input  logic             cfg_par_en,
    input  logic             cfg_par_odd,
    input  logic             cfg_two_stop,
    input  logic [DIV_W-1:0] cfg_div,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    output logic             rx_par_err,
    output logic             rx_frm_err
);
    rx_state_e              state, nxt;
    logic                   line_s, line_q, fall;
    logic                   tmr_load, tick;
    logic [DIV_W-1:0]       tmr_val;
    logic [GROUP_MAX-1:0]   shreg, group;
    logic [CNT_W-1:0]       bitcnt, last_bit;
    logic                   stop_idx, frm_seen, par_bad;

    rx_line_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .line_in(rx_line), .line_out(line_s)
    );

    rx_bit_timer #(.W(DIV_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .tick(tick)
    );

    rx_parity_check #(.N(GROUP_MAX)) u_par (
        .group(group), .par_en(cfg_par_en), .par_odd(cfg_par_odd), .par_err(par_bad)
    );

    assign last_bit = cfg_len8 ? CNT_W'(GROUP_MAX - 1) : CNT_W'(GROUP_MAX - 2);
    assign group    = cfg_len8 ? shreg : {1'b0, shreg[GROUP_MAX-1:1]};
    assign fall     = line_q & ~line_s;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    // Next state and timer control
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = cfg_div - 1'b1;
        unique case (state)
            RX_IDLE: if (fall) begin
                tmr_load = 1'b1;
                tmr_val  = (cfg_div >> 1) - 1'b1;
                nxt      = RX_START;
            end
            RX_START: if (tick) begin
                if (line_s) nxt = RX_IDLE;
                else begin
                    tmr_load = 1'b1;
                    nxt      = RX_DATA;
                end
            end
            RX_DATA: if (tick) begin
                tmr_load = 1'b1;
                if (bitcnt == last_bit) nxt = RX_STOP;
            end
            RX_STOP: if (tick) begin
                if (cfg_two_stop && !stop_idx) tmr_load = 1'b1;
                else                           nxt      = RX_DONE;
            end
            RX_DONE: nxt = RX_IDLE;
            default: nxt = RX_IDLE;
        endcase
    end

    // Frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q   <= 1'b1;
            shreg    <= '0;
            bitcnt   <= '0;
            stop_idx <= 1'b0;
            frm_seen <= 1'b0;
        end else begin
            line_q <= line_s;
            if (state == RX_START && tick && !line_s) begin
                bitcnt   <= '0;
                stop_idx <= 1'b0;
                frm_seen <= 1'b0;
            end
            if (state == RX_DATA && tick) begin
                shreg  <= {line_s, shreg[GROUP_MAX-1:1]};
                bitcnt <= bitcnt + 1'b1;
            end
            if (state == RX_STOP && tick) begin
                stop_idx <= 1'b1;
                if (!line_s) frm_seen <= 1'b1;
            end
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data    <= '0;
            rx_valid   <= 1'b0;
            rx_par_err <= 1'b0;
            rx_frm_err <= 1'b0;
        end else begin
            rx_valid <= (state == RX_DONE);
            if (state == RX_DONE) begin
                rx_data    <= group;
                rx_par_err <= par_bad;
                rx_frm_err <= frm_seen;
            end
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R4
    AST_NO_PAR_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !cfg_par_en) |-> !rx_par_err); // R6
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> ($stable(rx_data) && $stable(rx_par_err) && $stable(rx_frm_err))); // R10
    AST_FRM_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_frm_err) |-> rx_valid); // R7
    AST_SEVEN_BIT_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !cfg_len8) |-> !rx_data[7]); // R3
endmodule

// File: tb/async_rx_test.sv
module async_rx_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line = 1'b1;
    logic        len8 = 1'b1, par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
    logic [11:0] div = 12'd16;
    logic [7:0]  rx_data;
    logic        rx_valid, rx_par_err, rx_frm_err;

    int checks = 0, errors = 0, vcount = 0, double_hi = 0;
    logic prev_v = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    async_rx #(.DIV_W(12)) uut (
        .clk(clk), .rst_n(rst_n), .rx_line(line),
        .cfg_len8(len8), .cfg_par_en(par_en), .cfg_par_odd(par_odd),
        .cfg_two_stop(two_stop), .cfg_div(div),
        .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err)
    );

    always @(negedge clk) begin
        if (rx_valid) vcount++;
        if (rx_valid && prev_v) double_hi++;
        prev_v = rx_valid;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int n);
        line = v;
        repeat (n) @(negedge clk);
    endtask

    // Send one frame; bad_stop = index of the stop bit forced to 0, or -1 for none.
    task automatic send(input logic [7:0] grp, input int nb, input int nstop,
                        input int bad_stop, input int per);
        hold(1'b0, per);
        for (int i = 0; i < nb; i++) hold(grp[i], per);
        for (int s = 0; s < nstop; s++) hold((s == bad_stop) ? 1'b0 : 1'b1, per);
        hold(1'b1, 2 * per);
    endtask

    task automatic run_case(input logic [7:0] payload, input bit inj_par,
                            input int bad_stop, input int per, input string tag);
        int nb, nstop, v0;
        logic [7:0] grp, low;
        logic p;
        bit exp_par, exp_frm;
        nb    = len8 ? 8 : 7;
        nstop = two_stop ? 2 : 1;
        grp   = payload & ((8'h1 << nb) - 1);
        if (par_en) begin
            low = grp & ((8'h1 << (nb - 1)) - 1);
            p   = (^low) ^ par_odd ^ inj_par;
            grp = low | ({7'd0, p} << (nb - 1));
        end
        exp_par = par_en & inj_par;
        exp_frm = (bad_stop >= 0);
        v0 = vcount;
        send(grp, nb, nstop, bad_stop, per);
        check(vcount == v0 + 1, {tag, " R4 one valid"}, vcount - v0, 1);
        check(rx_data == grp, {tag, " R3 data"}, rx_data, grp);
        check(rx_par_err == exp_par, par_en ? {tag, " R5 parity"} : {tag, " R6 parity off"},
              rx_par_err, exp_par);
        check(rx_frm_err == exp_frm, two_stop ? {tag, " R8 two stop"} : {tag, " R7 framing"},
              rx_frm_err, exp_frm);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(rx_data == 8'h00 && !rx_valid && !rx_par_err && !rx_frm_err, "R1 reset",
              {rx_valid, rx_par_err, rx_frm_err, rx_data}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // Every byte, 8 bits, no parity, one stop bit.
        for (int b = 0; b < 256; b++) run_case(8'(b), 1'b0, -1, 16, "sweep8");

        // All configurations with parity and stop-bit faults.
        for (int c = 0; c < 16; c++) begin
            len8 = c[0]; par_en = c[1]; par_odd = c[2]; two_stop = c[3];
            for (int k = 0; k < 8; k++) begin
                int bs;
                bs = (k % 4 == 2) ? (two_stop ? 1 : 0) : ((k % 4 == 3) ? 0 : -1);
                run_case(8'(k * 37 + 5), (k % 3 == 1), bs, 16, "cfg");
            end
        end

        // R10: outputs held while the line is idle.
        begin
            logic [7:0] d0;
            d0 = rx_data;
            hold(1'b1, 100);
            check(rx_data == d0, "R10 hold", rx_data, d0);
        end

        // R2: a short low pulse is abandoned, then a proper frame follows.
        len8 = 1; par_en = 0; par_odd = 0; two_stop = 0;
        begin
            int v0;
            v0 = vcount;
            hold(1'b0, 3);
            hold(1'b1, 40);
            check(vcount == v0, "R2 glitch ignored", vcount - v0, 0);
            run_case(8'hA5, 1'b0, -1, 16, "R2 after glitch");
        end

        // R9: rate mismatch of about 3 percent.
        div = 12'd32;
        for (int m = 0; m < 2; m++)
            for (int k = 0; k < 16; k++)
                run_case(8'(k * 53 + 1), 1'b0, -1, (m == 0) ? 31 : 33, "R9 mismatch");

        check(double_hi == 0, "R4 pulse width", double_hi, 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule